// File: doc/BRIEF.md
# Post-Update Shifted-Address Load Unit

This unit performs the execute and writeback stages of a family of indexed loads that update their base register afterwards, on a 64-bit register file. The memory address is not a base-plus-offset sum: it is the base operand shifted left by one more than a small shift field. After the data returns, the destination register receives the loaded value, zero- or sign-extended according to the operation, and the base register receives the plain sum of the base and index operands as they stood when the operation was accepted.

One operation is accepted at a time through a valid/ready pair. The unit registers the operands, checks that the form is legal, issues a single-beat read with a valid/ready handshake, waits for a response-valid pulse, and then drives both register write ports together for one cycle. An illegal form raises a one-cycle flag and produces neither a memory read nor a register write. No status register is touched by any operation.

Top module: `shpost_load_unit`

## Requirements
- R1: The read address is the base operand shifted left by (sh + 1) positions; bits shifted beyond the top of the 64-bit word are lost, the index operand has no effect on the address, and `mem_req_size` repeats `op_size`.
- R2: The base write port writes `ra_val + rb_val` (modulo 2^64) of the operands latched at acceptance, to index `ra_idx`.
- R3: Size encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes; the loaded bytes sit right-justified in `mem_rsp_data`. With `op_signed` = 0 the destination receives those bytes with every higher bit cleared, whatever the higher response bits hold.
- R4: With `op_signed` = 1 and size 1 or 2, every destination bit above the loaded data copies the most significant loaded bit.
- R5: Size 3 writes all 64 response bits unchanged, and `op_signed` has no effect on it.
- R6: A form is illegal when `ra_idx` is 0, when `ra_idx` equals `rt_idx`, or when `op_signed` = 1 with size 0; then `invalid` is high for exactly the cycle after acceptance, no read is issued and neither write port is enabled.
- R7: `rt_we` and `ra_we` rise together for exactly one cycle, the cycle after the response is taken, with `rt_widx` = `rt_idx`.
- R8: An operation is accepted only when `op_valid` and `op_ready` are both high; `op_ready` is low from acceptance until writeback; `mem_req_valid` stays high with a stable address until `mem_req_ready`; input changes while busy have no effect.
- R9: After reset `op_ready` is 1 and `mem_req_valid`, `rt_we`, `ra_we` and `invalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation can be taken |
| op_size | input | 2 | Access size code (0..3 = 1,2,4,8 bytes) |
| op_signed | input | 1 | Sign-extend the loaded data |
| ra_val | input | 64 | Base operand |
| rb_val | input | 64 | Index operand |
| ra_idx | input | 5 | Base register index |
| rt_idx | input | 5 | Destination register index |
| sh | input | 3 | Shift field, address shift is sh+1 |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid pulse |
| mem_rsp_data | input | 64 | Read data, right-justified |
| rt_we | output | 1 | Destination write enable |
| rt_widx | output | 5 | Destination write index |
| rt_wdata | output | 64 | Destination write data |
| ra_we | output | 1 | Base write enable |
| ra_widx | output | 5 | Base write index |
| ra_wdata | output | 64 | Base write data |
| invalid | output | 1 | Illegal form pulse |

## Verification
On every cycle the assertions check that the two write ports move together and never target register 0 or the same index, that an illegal-form pulse never coincides with a write, that a pending read holds its address, that request, writeback and illegal pulse are mutually exclusive, and that a zero-extended byte load leaves the upper bits clear. The values themselves — the shifted address for every shift, the extended result for every size and sign choice, the base sum with carries, and the immunity to operand changes while busy — are shown only by the bench sweeping all sizes, sign choices and shift values against arithmetic expectations, with stalls on both handshakes.

// File: rtl/shpost_pkg.sv
package shpost_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ld_state_e;

  localparam int unsigned NUM_SIZES = 4;
endpackage

// File: rtl/shpost_addr_gen.sv
module shpost_addr_gen #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SH_W = 3
) (
  input  logic [XLEN-1:0] base,
  input  logic [SH_W-1:0] sh,
  output logic [XLEN-1:0] addr
);
  localparam int unsigned AMT_W = SH_W + 1;

  logic [AMT_W-1:0] amount;

  always_comb begin
    amount = {1'b0, sh} + AMT_W'(1);
    addr   = base << amount;
  end
endmodule

// File: rtl/shpost_legal_chk.sv
module shpost_legal_chk #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] base_idx,
  input  logic [IDX_W-1:0] dest_idx,
  input  logic [1:0]       size,
  input  logic             sgn,
  output logic             bad_form
);
  import shpost_pkg::*;

  logic base_zero;
  logic overlap;
  logic no_signed_byte;

  always_comb begin
    base_zero      = (base_idx == '0);
    overlap        = (base_idx == dest_idx);
    no_signed_byte = sgn && (size == SZ_BYTE);
    bad_form       = base_zero || overlap || no_signed_byte;
  end
endmodule

// File: rtl/shpost_extend.sv
module shpost_extend #(
  parameter int unsigned XLEN = 64
) (
  input  logic [1:0]      size,
  input  logic            sgn,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] result
);
  import shpost_pkg::*;

  logic [XLEN-1:0] lane [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    localparam int unsigned W = 8 << k;
    if (W >= XLEN) begin : g_full
      assign lane[k] = raw;
    end else begin : g_part
      logic fill;
      assign fill    = sgn & raw[W-1];
      assign lane[k] = {{(XLEN-W){fill}}, raw[W-1:0]};
    end
  end

  assign result = lane[size];
endmodule

// File: rtl/shpost_load_unit.sv
module shpost_load_unit #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [1:0]       op_size,
  input  logic             op_signed,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  rb_val,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [SH_W-1:0]  sh,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [XLEN-1:0]  mem_req_addr,
  output logic [1:0]       mem_req_size,
  input  logic             mem_rsp_valid,
  input  logic [XLEN-1:0]  mem_rsp_data,
  output logic             rt_we,
  output logic [IDX_W-1:0] rt_widx,
  output logic [XLEN-1:0]  rt_wdata,
  output logic             ra_we,
  output logic [IDX_W-1:0] ra_widx,
  output logic [XLEN-1:0]  ra_wdata,
  output logic             invalid
);
  import shpost_pkg::*;

  ld_state_e        state_q;
  logic [XLEN-1:0]  ea_q;
  logic [XLEN-1:0]  sum_q;
  logic [1:0]       size_q;
  logic             signed_q;
  logic [IDX_W-1:0] ra_idx_q;
  logic [IDX_W-1:0] rt_idx_q;
  logic             invalid_q;
  logic             rt_we_q;
  logic             ra_we_q;
  logic [XLEN-1:0]  rt_data_q;
  logic [XLEN-1:0]  ra_data_q;

  logic [XLEN-1:0]  ea_next;
  logic [XLEN-1:0]  ext_data;
  logic             bad_form;
  logic             accept;

  shpost_addr_gen #(.XLEN(XLEN), .SH_W(SH_W)) u_addr (
    .base (ra_val),
    .sh   (sh),
    .addr (ea_next)
  );

  shpost_legal_chk #(.IDX_W(IDX_W)) u_legal (
    .base_idx (ra_idx),
    .dest_idx (rt_idx),
    .size     (op_size),
    .sgn      (op_signed),
    .bad_form (bad_form)
  );

  shpost_extend #(.XLEN(XLEN)) u_ext (
    .size   (size_q),
    .sgn    (signed_q),
    .raw    (mem_rsp_data),
    .result (ext_data)
  );

  assign accept = op_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ea_q      <= '0;
      sum_q     <= '0;
      size_q    <= '0;
      signed_q  <= 1'b0;
      ra_idx_q  <= '0;
      rt_idx_q  <= '0;
      invalid_q <= 1'b0;
      rt_we_q   <= 1'b0;
      ra_we_q   <= 1'b0;
      rt_data_q <= '0;
      ra_data_q <= '0;
    end else begin
      invalid_q <= 1'b0;
      rt_we_q   <= 1'b0;
      ra_we_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ea_q     <= ea_next;
            sum_q    <= ra_val + rb_val;
            size_q   <= op_size;
            signed_q <= op_signed;
            ra_idx_q <= ra_idx;
            rt_idx_q <= rt_idx;
            if (bad_form) begin
              invalid_q <= 1'b1;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rt_we_q   <= 1'b1;
            ra_we_q   <= 1'b1;
            rt_data_q <= ext_data;
            ra_data_q <= sum_q;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_ready      = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign mem_req_size  = size_q;
  assign rt_we         = rt_we_q;
  assign rt_widx       = rt_idx_q;
  assign rt_wdata      = rt_data_q;
  assign ra_we         = ra_we_q;
  assign ra_widx       = ra_idx_q;
  assign ra_wdata      = ra_data_q;
  assign invalid       = invalid_q;
endmodule

// File: rtl/shpost_load_unit_chk.sv
module shpost_load_unit_chk #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned SH_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             op_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [XLEN-1:0]  mem_req_addr,
  input logic             rt_we,
  input logic             ra_we,
  input logic [IDX_W-1:0] rt_widx,
  input logic [IDX_W-1:0] ra_widx,
  input logic [XLEN-1:0]  rt_wdata,
  input logic             invalid,
  input logic [1:0]       size_q,
  input logic             signed_q
);
  // R7: both write ports move together
  a_r7_ports_paired: assert property (@(posedge clk) disable iff (rst)
    rt_we == ra_we);

  // R6: legal writes never hit register 0 or an overlapping pair
  a_r6_write_legal: assert property (@(posedge clk) disable iff (rst)
    ra_we |-> (ra_widx != '0) && (ra_widx != rt_widx));

  // R6: illegal pulse carries no write
  a_r6_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
    invalid |-> !rt_we && !ra_we && !mem_req_valid);

  // R8: pending request holds and keeps its address
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8: request, writeback and illegal pulse are exclusive; busy means not ready
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req_valid, rt_we, invalid}) && !(mem_req_valid && op_ready));

  // R3: unsigned byte load clears everything above the byte
  a_r3_byte_zero: assert property (@(posedge clk) disable iff (rst)
    rt_we && !signed_q && (size_q == 2'd0) |-> (rt_wdata[XLEN-1:8] == '0));
endmodule

bind shpost_load_unit shpost_load_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/shpost_load_unit_tb.sv
module shpost_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic        op_ready;
  logic [1:0]  op_size;
  logic        op_signed;
  logic [63:0] ra_val, rb_val;
  logic [4:0]  ra_idx, rt_idx;
  logic [2:0]  sh;
  logic        mem_req_valid, mem_req_ready;
  logic [63:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rt_we, ra_we, invalid;
  logic [4:0]  rt_widx, ra_widx;
  logic [63:0] rt_wdata, ra_wdata;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  shpost_load_unit u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_ext(input logic [1:0] sz, input logic sg, input logic [63:0] d);
    int unsigned w;
    logic [63:0] mask, v;
    w = 8 << sz;
    mask = (sz == 2'd3) ? '1 : ((64'd1 << w) - 64'd1);
    v = d & mask;
    if (sg && sz != 2'd3 && v[w-1]) v = v | ~mask;
    return v;
  endfunction

  task automatic run_op(input logic [1:0] sz, input logic sg, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] ai, input logic [4:0] ti,
                        input logic [2:0] s, input logic [63:0] d,
                        input int req_stall, input int rsp_stall, input logic expect_bad);
    logic [63:0] ea;
    ea = a << ({1'b0, s} + 4'd1);
    chk("R8 ready before offer", 64'(op_ready), 64'd1);
    op_valid = 1'b1; op_size = sz; op_signed = sg; ra_val = a; rb_val = b;
    ra_idx = ai; rt_idx = ti; sh = s;
    @(negedge clk);
    op_valid = 1'b0;
    if (expect_bad) begin
      chk("R6 invalid pulse", 64'(invalid), 64'd1);
      chk("R6 no request", 64'(mem_req_valid), 64'd0);
      chk("R6 no write", 64'({rt_we, ra_we}), 64'd0);
      @(negedge clk);
      chk("R6 pulse one cycle", 64'(invalid), 64'd0);
      chk("R6 still no write", 64'({rt_we, ra_we, mem_req_valid}), 64'd0);
      return;
    end
    // busy: offer a different op and scramble operands; must be ignored (R8)
    op_valid = 1'b1; ra_val = ~a; rb_val = a ^ b; ra_idx = ti; rt_idx = 5'd0; sh = ~s;
    chk("R8 busy not ready", 64'(op_ready), 64'd0);
    chk("R6 legal no flag", 64'(invalid), 64'd0);
    chk("R1 address", mem_req_addr, ea);
    chk("R1 size echo", 64'(mem_req_size), 64'(sz));
    for (int i = 0; i < req_stall; i++) begin
      chk("R8 request held", 64'(mem_req_valid), 64'd1);
      @(negedge clk);
      chk("R8 address stable", mem_req_addr, ea);
    end
    chk("R8 request valid", 64'(mem_req_valid), 64'd1);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R8 request dropped", 64'(mem_req_valid), 64'd0);
    for (int i = 0; i < rsp_stall; i++) begin
      @(negedge clk);
      chk("R7 no early write", 64'({rt_we, ra_we}), 64'd0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = d; op_valid = 1'b0;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = ~d;
    chk("R7 both enables", 64'({rt_we, ra_we}), 64'd3);
    chk("R7 dest index", 64'(rt_widx), 64'(ti));
    chk("R2 base index", 64'(ra_widx), 64'(ai));
    chk("R2 base sum", ra_wdata, a + b);
    if (sz == 2'd3) chk("R5 doubleword", rt_wdata, d);
    else if (sg)   chk("R4 sign extend", rt_wdata, exp_ext(sz, sg, d));
    else           chk("R3 zero extend", rt_wdata, exp_ext(sz, sg, d));
    @(negedge clk);
    chk("R7 single cycle", 64'({rt_we, ra_we}), 64'd0);
    chk("R8 busy offer ignored", 64'({op_ready, mem_req_valid}), 64'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] pats [2];
    pats[0] = 64'hA55A_3C4B_2D1E_0F70;
    pats[1] = 64'hF0E1_D2C3_B4A5_9687;
    rst = 1'b1; op_valid = 1'b0; op_size = '0; op_signed = 1'b0;
    ra_val = '0; rb_val = '0; ra_idx = '0; rt_idx = '0; sh = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset ready", 64'(op_ready), 64'd1);
    chk("R9 reset outputs", 64'({mem_req_valid, rt_we, ra_we, invalid}), 64'd0);

    for (int sz = 0; sz < 4; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int s = 0; s < 8; s++)
          for (int p = 0; p < 2; p++) begin
            if (sg == 1 && sz == 0) continue;
            run_op(2'(sz), 1'(sg),
                   64'h8123_4567_89AB_CDEF ^ (64'(s) << 40) ^ (p ? 64'hFFFF : 64'h0),
                   64'hFFFF_0000_0000_0001 + 64'(s * 3 + p),
                   5'(1 + s), 5'(20 + p), 3'(s), pats[p], s % 3, (s + p) % 2, 1'b0);
          end

    // R5: signed doubleword equals unsigned doubleword
    run_op(2'd3, 1'b1, 64'h1, 64'h2, 5'd3, 5'd4, 3'd7, 64'h8000_0000_0000_0001, 0, 0, 1'b0);
    // R6: illegal forms
    run_op(2'd1, 1'b0, 64'h10, 64'h1, 5'd0, 5'd4, 3'd0, 64'h0, 0, 0, 1'b1);
    run_op(2'd2, 1'b1, 64'h10, 64'h1, 5'd9, 5'd9, 3'd1, 64'h0, 0, 0, 1'b1);
    run_op(2'd0, 1'b1, 64'h10, 64'h1, 5'd5, 5'd6, 3'd2, 64'h0, 0, 0, 1'b1);
    // unit still works after illegal forms
    run_op(2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'd31, 5'd30, 3'd0, 64'hFF, 2, 3, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule